// File: doc/BRIEF.md
# Execute-Stage Operand Forwarding Selector

This block sits beside the execute stage of a five-stage, single-issue pipeline with 32 architectural registers. For each of the two source operands of the instruction now in execute, it decides where the operand value comes from. It can take the value read from the register file in decode. It can instead take a newer result that an older instruction has computed but not yet written back. That newer result sits either in the memory-stage pipeline register or in the writeback-stage pipeline register.

The block is purely combinational. Its inputs are the two source register numbers of the execute-stage instruction, and the destination register number and write enable of the instructions in the memory and writeback stages. Its outputs are two 2-bit selects, one for each operand, that steer the operand muxes in the datapath. Those muxes, stall logic and forwarding for branch comparison in decode are not part of this block.

Top module: `fwd_select`

## Requirements
- R1: When the memory stage writes a register (`mem_we_i`=1), its destination `mem_rd_i` is nonzero, and it equals a source number, that operand's select is 2'b10.
- R2: When the writeback stage writes a register, its nonzero destination equals a source number, and the memory stage does not match that source under R1, that operand's select is 2'b01.
- R3: A source number of 0 always yields select 2'b00, whatever the destination numbers and write enables are.
- R4: When the memory stage and the writeback stage both match the same source, the select is 2'b10, so the more recent result wins.
- R5: The select for operand A (`ex_rs_i`) depends only on `ex_rs_i` and the stage inputs. The select for operand B (`ex_rt_i`) is formed the same way from `ex_rt_i`. Each select is independent of the other source number.
- R6: A stage whose write enable is 0 never causes forwarding, even when its destination number equals the source.
- R7: When no stage matches a source, that operand's select is 2'b00, which picks the register-file value.
- R8: A select never takes the value 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_rs_i | input | 5 | First source register number of the execute-stage instruction |
| ex_rt_i | input | 5 | Second source register number of the execute-stage instruction |
| mem_rd_i | input | 5 | Destination register number held in the memory-stage register |
| mem_we_i | input | 1 | Memory-stage instruction writes a register |
| wb_rd_i | input | 5 | Destination register number held in the writeback-stage register |
| wb_we_i | input | 1 | Writeback-stage instruction writes a register |
| fwd_a_o | output | 2 | Operand A select: 00 register file, 10 memory stage, 01 writeback stage |
| fwd_b_o | output | 2 | Operand B select, encoded like fwd_a_o |

## Verification
The hardest case to reach from the ports is a double hazard. It needs both later stages writing, both holding the same nonzero destination, and that destination equal to a source number. With uniform 5-bit register numbers this happens in only about one case in a thousand. The random stimulus therefore draws register numbers from a small pool, so that matches, double matches and register zero come up often. Directed cases then set up the double hazard, a double hazard where the memory stage does not write, and the zero-register case on each operand.

// File: rtl/fwd_select_pkg.sv
package fwd_select_pkg;
  localparam int unsigned REG_W = 5;

  typedef enum logic [1:0] {
    FWD_RF  = 2'b00,
    FWD_WB  = 2'b01,
    FWD_MEM = 2'b10
  } fwd_sel_e;
endpackage

// File: rtl/fwd_stage_hit.sv
// One later stage compared against one source operand.
module fwd_stage_hit #(
  parameter int unsigned REG_W = 5
) (
  input  logic [REG_W-1:0] src_i,
  input  logic [REG_W-1:0] dst_i,
  input  logic             we_i,
  output logic             hit_o
);
  logic dst_nonzero;
  assign dst_nonzero = |dst_i;
  assign hit_o       = we_i && dst_nonzero && (dst_i == src_i);
endmodule

// File: rtl/fwd_operand_sel.sv
module fwd_operand_sel
  import fwd_select_pkg::*;
#(
  parameter int unsigned REG_W = 5
) (
  input  logic [REG_W-1:0] src_i,
  input  logic [REG_W-1:0] mem_rd_i,
  input  logic             mem_we_i,
  input  logic [REG_W-1:0] wb_rd_i,
  input  logic             wb_we_i,
  output logic [1:0]       sel_o
);
  logic mem_hit, wb_hit;
  fwd_sel_e sel;

  fwd_stage_hit #(.REG_W(REG_W)) u_mem_hit (
    .src_i(src_i), .dst_i(mem_rd_i), .we_i(mem_we_i), .hit_o(mem_hit)
  );
  fwd_stage_hit #(.REG_W(REG_W)) u_wb_hit (
    .src_i(src_i), .dst_i(wb_rd_i), .we_i(wb_we_i), .hit_o(wb_hit)
  );

  // nearest producer first
  always_comb begin
    if (mem_hit)     sel = FWD_MEM;
    else if (wb_hit) sel = FWD_WB;
    else             sel = FWD_RF;
  end

  assign sel_o = sel;
endmodule

// File: rtl/fwd_select.sv
module fwd_select
  import fwd_select_pkg::*;
#(
  parameter int unsigned NUM_SRC = 2
) (
  input  logic [REG_W-1:0] ex_rs_i,
  input  logic [REG_W-1:0] ex_rt_i,
  input  logic [REG_W-1:0] mem_rd_i,
  input  logic             mem_we_i,
  input  logic [REG_W-1:0] wb_rd_i,
  input  logic             wb_we_i,
  output logic [1:0]       fwd_a_o,
  output logic [1:0]       fwd_b_o
);
  logic [NUM_SRC-1:0][REG_W-1:0] src;
  logic [NUM_SRC-1:0][1:0]       sel;

  assign src[0] = ex_rs_i;
  assign src[1] = ex_rt_i;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    fwd_operand_sel #(.REG_W(REG_W)) u_sel (
      .src_i   (src[g]),
      .mem_rd_i(mem_rd_i),
      .mem_we_i(mem_we_i),
      .wb_rd_i (wb_rd_i),
      .wb_we_i (wb_we_i),
      .sel_o   (sel[g])
    );
  end

  assign fwd_a_o = sel[0];
  assign fwd_b_o = sel[1];
endmodule

// File: rtl/fwd_select_chk.sv
module fwd_select_chk
  import fwd_select_pkg::*;
(
  input logic [REG_W-1:0] ex_rs_i,
  input logic [REG_W-1:0] ex_rt_i,
  input logic [REG_W-1:0] mem_rd_i,
  input logic             mem_we_i,
  input logic [REG_W-1:0] wb_rd_i,
  input logic             wb_we_i,
  input logic [1:0]       fwd_a_o,
  input logic [1:0]       fwd_b_o
);
  always_comb begin
    // a memory-stage select implies a writing, matching producer
    assert_mem_src_a_R1: assert (fwd_a_o != 2'b10 || (mem_we_i && mem_rd_i == ex_rs_i))
      else $error("R1 operand A");
    assert_mem_src_b_R1: assert (fwd_b_o != 2'b10 || (mem_we_i && mem_rd_i == ex_rt_i))
      else $error("R1 operand B");
    assert_wb_src_a_R2: assert (fwd_a_o != 2'b01 || (wb_we_i && wb_rd_i == ex_rs_i))
      else $error("R2 operand A");
    assert_wb_src_b_R2: assert (fwd_b_o != 2'b01 || (wb_we_i && wb_rd_i == ex_rt_i))
      else $error("R2 operand B");
    assert_zero_a_R3: assert (ex_rs_i != '0 || fwd_a_o == 2'b00) else $error("R3 operand A");
    assert_zero_b_R3: assert (ex_rt_i != '0 || fwd_b_o == 2'b00) else $error("R3 operand B");
    assert_newest_a_R4: assert (!(mem_we_i && mem_rd_i == ex_rs_i && ex_rs_i != '0) || fwd_a_o == 2'b10)
      else $error("R4 operand A");
    assert_same_src_R5: assert (ex_rs_i != ex_rt_i || fwd_a_o == fwd_b_o) else $error("R5");
    assert_idle_R6: assert ((mem_we_i || wb_we_i) || (fwd_a_o == 2'b00 && fwd_b_o == 2'b00))
      else $error("R6");
    assert_legal_R8: assert (fwd_a_o != 2'b11 && fwd_b_o != 2'b11) else $error("R8");
  end
endmodule

bind fwd_select fwd_select_chk u_chk (
  .ex_rs_i(ex_rs_i), .ex_rt_i(ex_rt_i), .mem_rd_i(mem_rd_i), .mem_we_i(mem_we_i),
  .wb_rd_i(wb_rd_i), .wb_we_i(wb_we_i), .fwd_a_o(fwd_a_o), .fwd_b_o(fwd_b_o)
);

// File: tb/fwd_select_test.sv
`timescale 1ns/1ps
module fwd_select_test;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [4:0] rs, rt, mrd, wrd;
  logic       mwe, wwe;
  logic [1:0] fa, fb;
  int         n_chk = 0;
  int         n_err = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  fwd_select uut (
    .ex_rs_i(rs), .ex_rt_i(rt), .mem_rd_i(mrd), .mem_we_i(mwe),
    .wb_rd_i(wrd), .wb_we_i(wwe), .fwd_a_o(fa), .fwd_b_o(fb)
  );

  function automatic logic [1:0] ref_sel(logic [4:0] s, logic [4:0] m, logic me,
                                         logic [4:0] w, logic we);
    if (s == 5'd0)             return 2'b00;  // R3
    if (me && m == s)          return 2'b10;  // R1, R4
    if (we && w == s)          return 2'b01;  // R2
    return 2'b00;                             // R6, R7
  endfunction

  task automatic apply(input logic [4:0] a, b, m, input logic me,
                       input logic [4:0] w, input logic we, input string tag);
    logic [1:0] ea, eb;
    @(negedge clk);
    rs = a; rt = b; mrd = m; mwe = me; wrd = w; wwe = we;
    #1;
    ea = ref_sel(a, m, me, w, we);
    eb = ref_sel(b, m, me, w, we);
    n_chk++;
    if (fa !== ea) begin
      n_err++;
      $display("FAIL %s operand A: actual %b expected %b", tag, fa, ea);
    end
    n_chk++;
    if (fb !== eb) begin
      n_err++;
      $display("FAIL %s operand B: actual %b expected %b", tag, fb, eb);
    end
    n_chk++;
    if (fa === 2'b11 || fb === 2'b11) begin
      n_err++;
      $display("FAIL R8: actual %b/%b expected not 11", fa, fb);
    end
  endtask

  initial begin
    int unsigned seed = 32'd20240611;
    void'($urandom(seed));
    rs = '0; rt = '0; mrd = '0; mwe = 1'b0; wrd = '0; wwe = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    apply(0, 0, 0, 0, 0, 0, "R7 idle");
    apply(3, 4, 3, 1, 9, 1, "R1 mem on A");
    apply(3, 4, 4, 1, 9, 1, "R1 mem on B");
    apply(5, 6, 9, 1, 6, 1, "R2 wb on B");
    apply(5, 6, 5, 0, 5, 1, "R2 wb when mem idle");
    apply(7, 7, 7, 1, 7, 1, "R4 double hazard");
    apply(8, 2, 8, 0, 8, 0, "R6 no writers");
    apply(0, 0, 0, 1, 0, 1, "R3 zero both");
    apply(0, 12, 0, 1, 12, 1, "R3 zero A, R5 B wb");
    apply(11, 13, 11, 1, 13, 1, "R5 independent");
    apply(14, 15, 1, 1, 2, 1, "R7 no match");
    for (int i = 0; i < 3000; i++) begin
      apply($urandom % 4, $urandom % 4, $urandom % 4, 1'($urandom),
            $urandom % 4, 1'($urandom), "R1/R2/R4/R5 random");
    end
    for (int i = 0; i < 1000; i++) begin
      apply(5'($urandom), 5'($urandom), 5'($urandom), 1'($urandom),
            5'($urandom), 1'($urandom), "R7 random wide");
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
      $finish;
    end
  end
endmodule